// File: doc/BRIEF.md
# Iterative Logarithmic Multiplier with One Correction Step

This block forms an approximate product of two unsigned operands. It does not build the usual array of partial products. Each operand is split into a power of two (its leading one) and a residue (the bits below that leading one). The first estimate is the sum of three terms: the product of the two powers of two, and each residue shifted by the other operand's leading-one position. The part this estimate leaves out is exactly the product of the two residues. A second copy of the same estimating stage is applied to those residues, and its result is added to the first estimate.

The datapath is split into three register stages. The leading-one positions of the residues are found in the same stage that forms the first estimate, so the correction starts as soon as the residues exist. A new operand pair is accepted on every cycle. A valid flag travels alongside the data with the same latency. Use the block where a small, bounded underestimate of the product is acceptable, such as filters, image kernels and neural-network weights.

Top module: `ilm_mult`

## Requirements
- R1: For an accepted pair (a, b), the product equals T(a, b) + T(ra, rb). Here ra = a - 2^ka and rb = b - 2^kb, and ka and kb are the bit indices of the most significant set bit. T(x, y) = 2^(kx+ky) + rx·2^ky + ry·2^kx when both x and y are nonzero, and T(x, y) = 0 otherwise.
- R2: When either operand is zero, the product is zero.
- R3: The product never exceeds the exact product a·b.
- R4: When either operand is a power of two, the product equals a·b exactly.
- R5: out_valid rises exactly 3 clock cycles after the in_valid cycle that carried the pair. A cycle with in_valid low yields a cycle with out_valid low. Back-to-back pairs come out back to back and in order.
- R6: While reset is applied, and on the first cycle after it, out_valid is 0 and out_prod is 0.
- R7: With both operands all ones, the sum of the estimate and the correction fits in 2W bits with no carry out, and it matches R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair present this cycle |
| in_a | input | W | First unsigned operand |
| in_b | input | W | Second unsigned operand |
| out_valid | output | 1 | out_prod holds a result |
| out_prod | output | 2W | Approximate product |

## Verification
A wrong leading-one position or residue in the first stage changes the coarse estimate. It shows as a mismatch against the reference at the port 3 cycles after that pair enters. It often also breaks the bound below the exact product or the exactness for powers of two. A fault confined to the correction path shows only for pairs whose residues are both nonzero, so the random mix is weighted towards such operands. A valid flag out of step with the data shows at once, on the first pair, as a latency mismatch.

// File: rtl/ilm_pkg.sv
package ilm_pkg;
    // register stages from an accepted pair to its result
    localparam int unsigned ILM_LATENCY = 3;

    // bits needed to index a W-bit word, at least one
    function automatic int unsigned idx_bits(input int unsigned w);
        return (w < 2) ? 1 : $clog2(w);
    endfunction
endpackage

// File: rtl/ilm_shl.sv
module ilm_shl #(
    parameter int unsigned IN_W  = 8,
    parameter int unsigned OUT_W = 16,
    parameter int unsigned SW    = 3
) (
    input  logic [IN_W-1:0]  din,
    input  logic [SW-1:0]    amt,
    output logic [OUT_W-1:0] dout
);
    logic [OUT_W-1:0] lvl [0:SW];

    assign lvl[0] = OUT_W'(din);

    // one layer per bit of the shift amount
    for (genvar s = 0; s < SW; s++) begin : g_layer
        assign lvl[s+1] = amt[s] ? (lvl[s] << (1 << s)) : lvl[s];
    end

    assign dout = lvl[SW];
endmodule

// File: rtl/ilm_lead_enc.sv
module ilm_lead_enc
    import ilm_pkg::*;
#(
    parameter int unsigned W  = 8,
    localparam int unsigned IW = idx_bits(W)
) (
    input  logic [W-1:0]  val,
    output logic          nz,
    output logic [IW-1:0] pos,
    output logic [W-1:0]  res
);
    logic [W-1:0] hot;

    // leading-one detector: bit i is the top set bit
    for (genvar i = 0; i < W; i++) begin : g_lod
        if (i == W - 1) begin : g_top
            assign hot[i] = val[i];
        end else begin : g_low
            assign hot[i] = val[i] & ~(|val[W-1:i+1]);
        end
    end

    // priority encoder: one-hot position to binary index
    always_comb begin
        pos = '0;
        for (int i = 0; i < W; i++) begin
            if (hot[i]) pos = pos | IW'(i);
        end
    end

    assign nz  = |val;
    assign res = val & ~hot;

    always_comb begin
        a_r1_lead_onehot: assert ($onehot0(hot));
        if (nz) begin
            a_r1_residue_below_lead: assert ((res >> pos) == '0);
        end
    end
endmodule

// File: rtl/ilm_approx_term.sv
module ilm_approx_term
    import ilm_pkg::*;
#(
    parameter int unsigned W  = 8,
    localparam int unsigned IW = idx_bits(W),
    localparam int unsigned OW = 2 * W
) (
    input  logic          nz_x,
    input  logic          nz_y,
    input  logic [IW-1:0] k_x,
    input  logic [IW-1:0] k_y,
    input  logic [W-1:0]  r_x,
    input  logic [W-1:0]  r_y,
    output logic [OW-1:0] term
);
    logic [IW:0]   ksum;
    logic [OW-1:0] dec;
    logic [OW-1:0] sh_x;
    logic [OW-1:0] sh_y;

    assign ksum = {1'b0, k_x} + {1'b0, k_y};

    // decoder: 2^(kx+ky)
    for (genvar j = 0; j < OW; j++) begin : g_dec
        assign dec[j] = (ksum == (IW+1)'(j));
    end

    // cross-shifted residues
    ilm_shl #(.IN_W(W), .OUT_W(OW), .SW(IW)) u_sh_x (
        .din (r_x),
        .amt (k_y),
        .dout(sh_x)
    );

    ilm_shl #(.IN_W(W), .OUT_W(OW), .SW(IW)) u_sh_y (
        .din (r_y),
        .amt (k_x),
        .dout(sh_y)
    );

    assign term = (nz_x && nz_y) ? (dec + sh_x + sh_y) : '0;

    logic [OW-1:0] full_x;
    logic [OW-1:0] full_y;
    assign full_x = (OW'(1) << k_x) + OW'(r_x);
    assign full_y = (OW'(1) << k_y) + OW'(r_y);

    always_comb begin
        if (nz_x && nz_y) begin
            a_r3_stage_not_above: assert (term <= full_x * full_y);
        end
    end
endmodule

// File: rtl/ilm_mult.sv
module ilm_mult
    import ilm_pkg::*;
#(
    parameter int unsigned W = 8,
    localparam int unsigned IW = idx_bits(W),
    localparam int unsigned OW = 2 * W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [W-1:0]  in_a,
    input  logic [W-1:0]  in_b,
    output logic          out_valid,
    output logic [OW-1:0] out_prod
);
    typedef struct packed {
        logic          nz;
        logic [IW-1:0] pos;
        logic [W-1:0]  res;
    } lead_t;

    // ---- stage 1: split operands ----
    lead_t a_c, b_c, a_q, b_q;
    logic  v1;

    ilm_lead_enc #(.W(W)) u_enc_a (.val(in_a), .nz(a_c.nz), .pos(a_c.pos), .res(a_c.res));
    ilm_lead_enc #(.W(W)) u_enc_b (.val(in_b), .nz(b_c.nz), .pos(b_c.pos), .res(b_c.res));

    always_ff @(posedge clk) begin
        if (rst) begin
            v1  <= 1'b0;
            a_q <= '0;
            b_q <= '0;
        end else begin
            v1  <= in_valid;
            a_q <= a_c;
            b_q <= b_c;
        end
    end

    // ---- stage 2: first estimate, split residues ----
    logic [OW-1:0] est_c, est_q;
    lead_t         ra_c, rb_c, ra_q, rb_q;
    logic          v2, zero_q;

    ilm_approx_term #(.W(W)) u_first (
        .nz_x(a_q.nz), .nz_y(b_q.nz),
        .k_x (a_q.pos), .k_y(b_q.pos),
        .r_x (a_q.res), .r_y(b_q.res),
        .term(est_c)
    );

    ilm_lead_enc #(.W(W)) u_enc_ra (.val(a_q.res), .nz(ra_c.nz), .pos(ra_c.pos), .res(ra_c.res));
    ilm_lead_enc #(.W(W)) u_enc_rb (.val(b_q.res), .nz(rb_c.nz), .pos(rb_c.pos), .res(rb_c.res));

    always_ff @(posedge clk) begin
        if (rst) begin
            v2     <= 1'b0;
            est_q  <= '0;
            ra_q   <= '0;
            rb_q   <= '0;
            zero_q <= 1'b0;
        end else begin
            v2     <= v1;
            est_q  <= est_c;
            ra_q   <= ra_c;
            rb_q   <= rb_c;
            zero_q <= !(a_q.nz && b_q.nz);
        end
    end

    // ---- stage 3: correction and final sum ----
    logic [OW-1:0] corr_c;
    logic [OW:0]   sum_c;

    ilm_approx_term #(.W(W)) u_corr (
        .nz_x(ra_q.nz), .nz_y(rb_q.nz),
        .k_x (ra_q.pos), .k_y(rb_q.pos),
        .r_x (ra_q.res), .r_y(rb_q.res),
        .term(corr_c)
    );

    assign sum_c = {1'b0, est_q} + {1'b0, corr_c};

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_prod  <= '0;
        end else begin
            out_valid <= v2;
            out_prod  <= sum_c[OW-1:0];
        end
    end

    // ---- checks ----
    always_comb begin
        if (!rst && v2) begin
            a_r7_no_carry_out: assert (!sum_c[OW]);
        end
    end

    a_r2_zero_out: assert property (@(posedge clk) disable iff (rst)
        (v2 && zero_q) |=> (out_prod == '0));

    a_r5_valid_follow: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(v2));

    a_r1_corr_zero_when_residue_zero: assert property (@(posedge clk) disable iff (rst)
        (v2 && !(ra_q.nz && rb_q.nz)) |=> (out_prod == $past(est_q)));

    a_r6_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && out_prod == '0));
endmodule

// File: tb/tb_ilm_mult.sv
module tb_ilm_mult;
    localparam int unsigned W  = 8;
    localparam int unsigned OW = 2 * W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [W-1:0]  in_a = '0;
    logic [W-1:0]  in_b = '0;
    logic          out_valid;
    logic [OW-1:0] out_prod;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    int unsigned q_exp[$];
    int unsigned q_a[$];
    int unsigned q_b[$];
    int          q_cyc[$];

    ilm_mult #(.W(W)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_prod(out_prod)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int lead(input int unsigned x);
        int k = 0;
        for (int i = 0; i < 32; i++) if (x[i]) k = i;
        return k;
    endfunction

    function automatic int unsigned tterm(input int unsigned x, input int unsigned y);
        int kx, ky;
        if (x == 0 || y == 0) return 0;
        kx = lead(x);
        ky = lead(y);
        return (32'd1 << (kx + ky)) + ((x - (32'd1 << kx)) << ky) + ((y - (32'd1 << ky)) << kx);
    endfunction

    function automatic int unsigned model(input int unsigned a, input int unsigned b);
        int unsigned ra, rb;
        ra = (a == 0) ? 0 : a - (32'd1 << lead(a));
        rb = (b == 0) ? 0 : b - (32'd1 << lead(b));
        return tterm(a, b) + tterm(ra, rb);
    endfunction

    task automatic check(input bit ok, input string req, input int unsigned act, input int unsigned exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input bit v, input int unsigned a, input int unsigned b);
        @(negedge clk);
        in_valid = v;
        in_a = W'(a);
        in_b = W'(b);
        if (v) begin
            q_exp.push_back(model(a, b));
            q_a.push_back(a);
            q_b.push_back(b);
            q_cyc.push_back(cyc);
        end
    endtask

    // output monitor
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_valid) begin
                if (q_exp.size() == 0) begin
                    check(1'b0, "R5 unexpected out_valid", 1, 0);
                end else begin
                    int unsigned e, a, b, p;
                    int c;
                    e = q_exp.pop_front();
                    a = q_a.pop_front();
                    b = q_b.pop_front();
                    c = q_cyc.pop_front();
                    p = out_prod;
                    check(cyc == c + 3, "R5 latency", cyc - c, 3);
                    check(p == e, "R1 product", p, e);
                    check(p <= a * b, "R3 bound", p, a * b);
                    if (a == 0 || b == 0) check(p == 0, "R2 zero operand", p, 0);
                    if ((a != 0 && (a & (a - 1)) == 0) || (b != 0 && (b & (b - 1)) == 0))
                        check(p == a * b, "R4 power of two exact", p, a * b);
                    if (a == 255 && b == 255) check(p == 61056, "R7 all ones", p, 61056);
                end
            end else if (q_cyc.size() != 0 && q_cyc[0] + 3 == cyc) begin
                check(1'b0, "R5 missing out_valid", 0, 1);
            end
        end
    end

    // watchdog
    initial begin
        #(8 * 100000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R6 reset valid", out_valid, 0);
        check(out_prod == '0, "R6 reset product", out_prod, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0 && out_prod == '0, "R6 after reset", out_prod, 0);
        mon_on = 1'b1;

        // directed corner cases
        send(1, 20, 60);
        send(1, 0, 200);
        send(1, 173, 0);
        send(1, 0, 0);
        send(0, 0, 0);
        send(1, 255, 255);
        send(1, 128, 77);
        send(1, 91, 64);
        send(1, 1, 1);
        send(0, 0, 0);
        send(0, 0, 0);
        send(1, 1, 255);
        send(1, 200, 199);
        send(1, 96, 96);

        // random mix, biased to operands with rich residues
        for (int n = 0; n < 400; n++) begin
            int unsigned a, b;
            bit v;
            a = $urandom_range(0, 255);
            b = $urandom_range(0, 255);
            if ($urandom_range(0, 3) == 0) a = a | 32'h80 | 32'h3;
            v = ($urandom_range(0, 4) != 0);
            send(v, a, b);
        end
        send(0, 0, 0);

        for (int n = 0; n < 20 && q_exp.size() != 0; n++) @(negedge clk);
        check(q_exp.size() == 0, "R5 drained", q_exp.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule